// File: doc/BRIEF.md
# Pulse-Count Phrase Address Receiver

This block turns a two-wire trigger interface into playback commands for a phrase player. A host pulls a strobe line low, sends a burst of pulses on a second line, and releases the strobe. The number of pulses in that low window is the phrase address. On the release the block emits a one-cycle start pulse with that address. A window with no pulses emits a one-cycle stop pulse instead. A third input is an active-low power-down level. While it is low the block stays in standby and issues no commands. Power-down low, strobe low and pulse line high held together form a reset request, which also clears the address.

All three inputs are asynchronous to the system clock, which is much faster than the pulses. Each input passes through a two-flop synchroniser. Pulses are counted on rising edges of the synchronised pulse line. The count is 5 bits and wraps to zero after 32 pulses.

The control is a four-state machine:
- ST_STANDBY: power-down is asserted.
- ST_IDLE: running, with the strobe high.
- ST_COUNT: running, with the strobe low, and pulses are counted.
- ST_DISCARD: running, but the strobe was already low when the block left standby, so this partial window is dropped.

The transitions are:
- Any state goes to ST_STANDBY on power-down.
- ST_STANDBY goes to ST_IDLE on wake with the strobe high.
- ST_STANDBY goes to ST_DISCARD on wake with the strobe low.
- ST_IDLE goes to ST_COUNT when the strobe falls. The counter clears on this entry.
- ST_COUNT goes to ST_IDLE when the strobe rises. The command is issued on this transition.
- ST_DISCARD goes to ST_IDLE when the strobe rises. No command is issued.

Top module: `pulse_addr_rx`

## Requirements
- R1: After `rst_n` is released, `start_o`, `stop_o` and `reset_req_o` are 0 and `addr_o` is 0.
- R2: A strobe-low window with N pulses, 1 <= N <= 31, gives exactly one start pulse and no stop pulse, and `addr_o` equals N.
- R3: The pulse count wraps modulo 32. With 32 pulses the start is issued with address 0. With 33 pulses it is issued with address 1.
- R4: A strobe-low window with no pulse gives one stop pulse and no start pulse, and `addr_o` keeps its previous value.
- R5: `start_o` and `stop_o` are each high for exactly one clock cycle per command and are never high together.
- R6: Pulses while the strobe is high are ignored, and every window counts from zero.
- R7: While `pwr_n_in` is low, neither `start_o` nor `stop_o` is asserted.
- R8: While `pwr_n_in` is low, `strb_n_in` is low and `pls_in` is high, `reset_req_o` is high and `addr_o` is cleared to 0. `reset_req_o` is low otherwise.
- R9: A window already open when `pwr_n_in` rises is dropped: it gives no start and no stop.
- R10: `addr_o` changes only when a start is issued or a reset request clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| strb_n_in | input | 1 | Asynchronous strobe; the low level opens the counting window |
| pls_in | input | 1 | Asynchronous address pulse line |
| pwr_n_in | input | 1 | Asynchronous power-down; low holds the block in standby |
| start_o | output | 1 | One-cycle start-playback command |
| stop_o | output | 1 | One-cycle stop-playback command |
| addr_o | output | 5 | Phrase address of the last start; held until the next start or reset |
| reset_req_o | output | 1 | Reset request |

## Verification
The assertions check four things on every cycle:
- Start and stop are one cycle wide and never coincide.
- No command appears in standby.
- The address moves only together with a start or a reset request.
- The address reads zero whenever a reset request is raised.

Only the bench scenarios can show the counting itself:
- The sweep from zero to 33 pulses, including the wrap at 32.
- Pulses outside a window being ignored.
- A window opened during standby being discarded.
- A reset request being produced from the pin combination.

// File: rtl/pars_pkg.sv
package pars_pkg;

    localparam int unsigned ADDR_W_DEF = 5;
    localparam int unsigned SYNC_STAGES_DEF = 2;

    typedef enum logic [1:0] {
        ST_STANDBY = 2'd0,
        ST_IDLE    = 2'd1,
        ST_COUNT   = 2'd2,
        ST_DISCARD = 2'd3
    } rx_state_e;

endpackage

// File: rtl/pars_sync.sv
module pars_sync #(
    parameter int unsigned W = 1,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= RST_VAL;
                    else        chain[g] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= RST_VAL;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/pars_edge.sv
module pars_edge #(
    parameter int unsigned W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/pars_fsm.sv
module pars_fsm
    import pars_pkg::*;
#(
    parameter int unsigned ADDR_W = ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_s,
    input  logic              strb_s,
    input  logic              pls_s,
    input  logic              pls_rise,
    output logic              start_o,
    output logic              stop_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              reset_req_o
);
    rx_state_e         state_q, state_d;
    logic [ADDR_W-1:0] cnt_q;
    logic              seen_q;
    logic              rst_cond;
    logic              close_win;

    assign rst_cond  = !run_s && !strb_s && pls_s;
    assign close_win = run_s && (state_q == ST_COUNT) && strb_s;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STANDBY;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STANDBY: if (run_s) state_d = strb_s ? ST_IDLE : ST_DISCARD;
            ST_IDLE: begin
                if (!run_s)      state_d = ST_STANDBY;
                else if (!strb_s) state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (!run_s)     state_d = ST_STANDBY;
                else if (strb_s) state_d = ST_IDLE;
            end
            ST_DISCARD: begin
                if (!run_s)     state_d = ST_STANDBY;
                else if (strb_s) state_d = ST_IDLE;
            end
            default: state_d = ST_STANDBY;
        endcase
    end

    // pulse counter, cleared outside the counting state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else if (state_q != ST_COUNT) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else if (pls_rise) begin
            cnt_q  <= cnt_q + 1'b1;
            seen_q <= 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_o     <= 1'b0;
            stop_o      <= 1'b0;
            addr_o      <= '0;
            reset_req_o <= 1'b0;
        end else begin
            start_o     <= 1'b0;
            stop_o      <= 1'b0;
            reset_req_o <= rst_cond;
            if (rst_cond) begin
                addr_o <= '0;
            end else if (close_win) begin
                if (seen_q) begin
                    start_o <= 1'b1;
                    addr_o  <= cnt_q;
                end else begin
                    stop_o  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pulse_addr_rx.sv
module pulse_addr_rx
    import pars_pkg::*;
#(
    parameter int unsigned ADDR_W = ADDR_W_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strb_n_in,
    input  logic              pls_in,
    input  logic              pwr_n_in,
    output logic              start_o,
    output logic              stop_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              reset_req_o
);
    // bit 0 strobe (idle high), bit 1 pulse, bit 2 power (standby at reset)
    logic [2:0] raw;
    logic [2:0] synced;
    logic       strb_s;
    logic       pls_s;
    logic       run_s;
    logic       pls_rise;

    assign raw = {pwr_n_in, pls_in, strb_n_in};

    pars_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw),
        .q_o   (synced)
    );

    assign strb_s = synced[0];
    assign pls_s  = synced[1];
    assign run_s  = synced[2];

    pars_edge #(.W(1), .RST_VAL(1'b0)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (pls_s),
        .rise_o (pls_rise)
    );

    pars_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_s       (run_s),
        .strb_s      (strb_s),
        .pls_s       (pls_s),
        .pls_rise    (pls_rise),
        .start_o     (start_o),
        .stop_o      (stop_o),
        .addr_o      (addr_o),
        .reset_req_o (reset_req_o)
    );
endmodule

// File: rtl/pars_chk.sv
module pars_chk #(
    parameter int unsigned ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_s,
    input logic              start_o,
    input logic              stop_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic              reset_req_o
);
    // R5
    cmd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_o && stop_o));

    // R5
    start_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    // R5
    stop_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |=> !stop_o);

    // R7
    standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_s |=> !(start_o || stop_o));

    // R8
    reset_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_o |-> (addr_o == '0));

    // R10
    addr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(addr_o) |-> (start_o || reset_req_o));
endmodule

bind pulse_addr_rx pars_chk #(.ADDR_W(ADDR_W)) u_pars_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_s       (run_s),
    .start_o     (start_o),
    .stop_o      (stop_o),
    .addr_o      (addr_o),
    .reset_req_o (reset_req_o)
);

// File: tb/test_pulse_addr_rx.sv
module test_pulse_addr_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strb_n_in = 1'b1;
    logic       pls_in = 1'b0;
    logic       pwr_n_in = 1'b1;
    logic       start_o, stop_o, reset_req_o;
    logic [4:0] addr_o;

    int n_chk = 0;
    int n_fail = 0;
    int start_cnt = 0;
    int stop_cnt = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pulse_addr_rx i_pulse_addr_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .strb_n_in   (strb_n_in),
        .pls_in      (pls_in),
        .pwr_n_in    (pwr_n_in),
        .start_o     (start_o),
        .stop_o      (stop_o),
        .addr_o      (addr_o),
        .reset_req_o (reset_req_o)
    );

    always @(negedge clk) begin
        if (start_o) start_cnt++;
        if (stop_o)  stop_cnt++;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clr();
        @(negedge clk);
        start_cnt = 0;
        stop_cnt  = 0;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            pls_in = 1'b1;
            repeat (4) @(negedge clk);
            pls_in = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic window(input int n);
        @(negedge clk);
        strb_n_in = 1'b0;
        repeat (6) @(negedge clk);
        pulses(n);
        repeat (4) @(negedge clk);
        strb_n_in = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            summary();
        end
    end

    initial begin
        int exp_addr;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        check(start_o == 0 && stop_o == 0, "R1 commands idle", int'(start_o | stop_o), 0);
        check(addr_o == 0, "R1 address", int'(addr_o), 0);
        check(reset_req_o == 0, "R1 reset request", int'(reset_req_o), 0);
        repeat (6) @(negedge clk);

        // R2 R3 R4 R5 sweep of pulse counts
        exp_addr = 0;
        for (int n = 0; n <= 33; n++) begin
            clr();
            window(n);
            if (n == 0) begin
                check(stop_cnt == 1, "R4 stop pulse count (R5 width)", stop_cnt, 1);
                check(start_cnt == 0, "R4 no start", start_cnt, 0);
                check(int'(addr_o) == exp_addr, "R4 address kept", int'(addr_o), exp_addr);
            end else begin
                exp_addr = n % 32;
                check(start_cnt == 1, (n >= 32) ? "R3 start count" : "R2 start count (R5 width)", start_cnt, 1);
                check(stop_cnt == 0, "R2 no stop", stop_cnt, 0);
                check(int'(addr_o) == exp_addr, (n >= 32) ? "R3 wrapped address" : "R2 address", int'(addr_o), exp_addr);
            end
        end

        // R4 again after a nonzero address
        clr();
        window(0);
        check(stop_cnt == 1, "R4 stop after start", stop_cnt, 1);
        check(int'(addr_o) == exp_addr, "R4 address kept after stop", int'(addr_o), exp_addr);

        // R6 pulses with strobe high are ignored
        clr();
        pulses(3);
        repeat (8) @(negedge clk);
        check(start_cnt == 0 && stop_cnt == 0, "R6 no command outside window", start_cnt + stop_cnt, 0);
        window(2);
        check(int'(addr_o) == 2, "R6 count starts from zero", int'(addr_o), 2);

        // R7 standby ignores windows
        pwr_n_in = 1'b0;
        repeat (8) @(negedge clk);
        clr();
        window(0);
        check(start_cnt == 0 && stop_cnt == 0, "R7 no command in standby", start_cnt + stop_cnt, 0);
        check(int'(addr_o) == 2, "R7 address untouched", int'(addr_o), 2);

        // R8 reset combination
        strb_n_in = 1'b0;
        repeat (4) @(negedge clk);
        pls_in = 1'b1;
        repeat (6) @(negedge clk);
        check(reset_req_o == 1, "R8 reset request raised", int'(reset_req_o), 1);
        check(addr_o == 0, "R8 address cleared", int'(addr_o), 0);
        pls_in = 1'b0;
        repeat (6) @(negedge clk);
        check(reset_req_o == 0, "R8 reset request released", int'(reset_req_o), 0);

        // R9 window open at wake-up is discarded
        clr();
        pwr_n_in = 1'b1;
        repeat (8) @(negedge clk);
        pulses(4);
        repeat (4) @(negedge clk);
        strb_n_in = 1'b1;
        repeat (12) @(negedge clk);
        check(start_cnt == 0 && stop_cnt == 0, "R9 partial window dropped", start_cnt + stop_cnt, 0);
        check(addr_o == 0, "R10 address unchanged without start", int'(addr_o), 0);

        clr();
        window(7);
        check(start_cnt == 1 && int'(addr_o) == 7, "R9 next window after wake", int'(addr_o), 7);

        done = 1;
        summary();
    end
endmodule